// File: doc/BRIEF.md
# Register-Mapped Single-Word SPI Master

This block is an SPI master that moves one word per command. Software reaches it through a small word-addressed register port with separate write and read strobes. It chooses one of eight chip-select lines, the clock polarity and phase, the bit order for each direction and a word size of 8 or 16 bits. Writing the transmit register then launches a transfer. The block shifts the word out on MOSI, samples MISO at a programmable delay after each sampling edge, keeps the received word right-aligned, and sets a completion flag. Software clears that flag by writing zero to it.

Chip select comes only from a control bit and is never pulsed around words, so a frame of several words stays selected for its whole length. The serial clock rate comes from a separate half-period tick generator. Its period is a parameter of at least four core cycles.

Top module: `spi_word_master`

## Requirements
- R1: After reset every chip-select output is high and SCLK is low. The control, configuration, transmit, receive and cause registers read 0, and the timing register (word address 6) reads 0x40, which means its sample-delay field holds 1.
- R2: Control register (word address 0): bit 0 set drives low only the chip-select output whose index is in bits [4:2]; with bit 0 clear all outputs are high. Chip select does not change between words while bit 0 stays set.
- R3: Configuration register (word address 1): bit 11 gives the SCLK idle level. With bit 12 clear, data is sampled on the leading edge and MOSI is valid before the first edge. With bit 12 set, MOSI changes on the leading edge and data is sampled on the trailing edge.
- R4: Configuration bit 5 set makes a word 16 bits long (16 SCLK pulses); with it clear a word is 8 bits long.
- R5: Configuration bit 13 set sends the transmit word least significant bit first; with it clear the most significant bit of the word goes first.
- R6: Configuration bit 14 set places the first received bit at bit 0; with it clear the first received bit lands at bit 7 or 15. The result is right-aligned and the upper bits read zero.
- R7: A write to the transmit register (word address 2) while idle starts one transfer, and control bit 1 reads 1 while the transfer runs.
- R8: When a word completes, the cause register (word address 4) reads nonzero until software writes 0 to it.
- R9: A transmit-register write during a transfer has no effect: the word being sent and the transmit readback stay unchanged.
- R10: Timing bits [7:6] delay the MISO capture after the sampling edge. A value of 2 captures one core cycle later than a value of 1.
- R11: The receive register (word address 3) returns the last received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Chip selects, active low |

## Verification
A behavioural slave watches SCLK edges and serves MISO in the phase the mode asks for. Random transfers vary the mode, word size, both bit orders, the sample delay, the chip-select index and the data, so that a swapped edge, a wrong bit order or a wrong word length corrupts the captured MOSI or the received word. In a directed case the slave inverts MISO exactly two core cycles after each sampling edge, which separates delay value 1 from value 2. Further directed cases cover a transmit write during a transfer and a two-word frame in which chip select must stay low throughout.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
    localparam int REG_ADDR_W = 4;
    localparam int DATA_W     = 32;

    localparam logic [REG_ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [REG_ADDR_W-1:0] A_CFG    = 4'd1;
    localparam logic [REG_ADDR_W-1:0] A_TXD    = 4'd2;
    localparam logic [REG_ADDR_W-1:0] A_RXD    = 4'd3;
    localparam logic [REG_ADDR_W-1:0] A_CAUSE  = 4'd4;
    localparam logic [REG_ADDR_W-1:0] A_TIMING = 4'd6;

    localparam int B_SEL_EN  = 0;
    localparam int B_BUSY    = 1;
    localparam int B_SEL_IDX = 2;
    localparam int B_WIDE    = 5;
    localparam int B_CPOL    = 11;
    localparam int B_CPHA    = 12;
    localparam int B_TX_LSB  = 13;
    localparam int B_RX_LSB  = 14;
    localparam int B_DELAY   = 6;

    typedef struct packed {
        logic       wide;
        logic       cpol;
        logic       cpha;
        logic       tx_lsb;
        logic       rx_lsb;
        logic [1:0] dly;
    } xfer_cfg_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == CW'(HALF - 1));
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
    parameter int NUM_CS = 8,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [NUM_CS-1:0] cs_n_o
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign cs_n_o[g] = !(en_i && (idx_i == IDX_W'(g)));
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_word_pkg::*;
#(
    parameter int MAX_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] word_i,
    input  xfer_cfg_t           cfg_i,
    input  logic                idle_cpol_i,
    input  logic                tick_i,
    input  logic                miso_i,
    output logic                run_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic [MAX_BITS-1:0] rx_o
);
    localparam int NARROW = MAX_BITS / 2;
    localparam int CNT_W  = $clog2(2 * MAX_BITS + 1);
    localparam int IDX_W  = $clog2(MAX_BITS);

    typedef struct packed {
        logic                active;
        logic                sclk;
        logic [CNT_W-1:0]    edges;
        logic [IDX_W-1:0]    out_idx;
        logic [IDX_W-1:0]    in_idx;
        logic                pend;
        logic [1:0]          pcnt;
        xfer_cfg_t           cfg;
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx;
    } core_t;

    core_t            st_d, st_q;
    logic [IDX_W:0]   nbits;
    logic [CNT_W-1:0] total;
    logic [IDX_W-1:0] pos_in, pos_out, last_pos;
    logic             lead;

    always_comb begin
        nbits    = st_q.cfg.wide ? (IDX_W+1)'(MAX_BITS) : (IDX_W+1)'(NARROW);
        total    = CNT_W'({nbits, 1'b0});
        last_pos = IDX_W'(nbits - 1'b1);
        pos_in   = st_q.cfg.rx_lsb ? st_q.in_idx  : last_pos - st_q.in_idx;
        pos_out  = st_q.cfg.tx_lsb ? st_q.out_idx : last_pos - st_q.out_idx;
        lead     = ~st_q.edges[0];
        st_d     = st_q;
        done_o   = 1'b0;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active  = 1'b1;
                st_d.sclk    = cfg_i.cpol;
                st_d.edges   = '0;
                st_d.out_idx = '0;
                st_d.in_idx  = '0;
                st_d.pend    = 1'b0;
                st_d.pcnt    = '0;
                st_d.cfg     = cfg_i;
                st_d.tx      = word_i;
                st_d.rx      = '0;
            end
        end else begin
            if (st_q.pend) begin
                if (st_q.pcnt == 2'd0) begin
                    st_d.rx[pos_in] = miso_i;
                    st_d.in_idx     = st_q.in_idx + 1'b1;
                    st_d.pend       = 1'b0;
                end else begin
                    st_d.pcnt = st_q.pcnt - 1'b1;
                end
            end
            if (tick_i) begin
                st_d.sclk  = ~st_q.sclk;
                st_d.edges = st_q.edges + 1'b1;
                if (lead ^ st_q.cfg.cpha) begin
                    st_d.pend = 1'b1;
                    st_d.pcnt = st_q.cfg.dly;
                end else if (!(st_q.cfg.cpha && st_q.edges == '0)) begin
                    st_d.out_idx = st_q.out_idx + 1'b1;
                end
            end
            if (st_q.edges == total && !st_q.pend) begin
                st_d.active = 1'b0;
                done_o      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = st_q.active && (st_q.edges != total);
    assign busy_o = st_q.active;
    assign sclk_o = st_q.active ? st_q.sclk : idle_cpol_i;
    assign mosi_o = st_q.active & st_q.tx[pos_out];
    assign rx_o   = st_q.rx;

    // R4: the tick source stops once the word has all its edges
    p_no_tick_past_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.edges == total) |-> !tick_i)
        else $error("tick after final edge");

    // R3: an even edge count leaves SCLK at its idle level at completion
    p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (st_q.sclk == st_q.cfg.cpol))
        else $error("sclk not at idle level at completion");

    // R6: the received word holds while idle
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !start_i) |=> $stable(st_q.rx))
        else $error("rx changed while idle");
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_word_pkg::*;
#(
    parameter int NUM_CS    = 8,
    parameter int MAX_BITS  = 16,
    parameter int SCLK_HALF = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    output logic [NUM_CS-1:0]     spi_cs_n
);
    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    typedef struct packed {
        logic                cs_en;
        logic [CS_IDX_W-1:0] cs_idx;
        logic                wide;
        logic                cpol;
        logic                cpha;
        logic                tx_lsb;
        logic                rx_lsb;
        logic [1:0]          dly;
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx;
        logic                cause;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t               rg_d, rg_q;
    xfer_cfg_t           eng_cfg;
    logic                eng_run, eng_busy, eng_done, tick;
    logic                tx_wr, start;
    logic [MAX_BITS-1:0] eng_rx;
    logic [DATA_W-1:0]   rd_v;
    logic                unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:MAX_BITS];

    always_comb begin
        eng_cfg.wide   = rg_q.wide;
        eng_cfg.cpol   = rg_q.cpol;
        eng_cfg.cpha   = rg_q.cpha;
        eng_cfg.tx_lsb = rg_q.tx_lsb;
        eng_cfg.rx_lsb = rg_q.rx_lsb;
        eng_cfg.dly    = rg_q.dly;
    end

    assign tx_wr = bus_wr && (bus_addr == A_TXD);
    assign start = tx_wr && !eng_busy;

    always_comb begin
        rd_v = '0;
        case (bus_addr)
            A_CTRL: begin
                rd_v[B_SEL_EN]                = rg_q.cs_en;
                rd_v[B_BUSY]                  = eng_busy;
                rd_v[B_SEL_IDX +: CS_IDX_W]   = rg_q.cs_idx;
            end
            A_CFG: begin
                rd_v[B_WIDE]   = rg_q.wide;
                rd_v[B_CPOL]   = rg_q.cpol;
                rd_v[B_CPHA]   = rg_q.cpha;
                rd_v[B_TX_LSB] = rg_q.tx_lsb;
                rd_v[B_RX_LSB] = rg_q.rx_lsb;
            end
            A_TXD:    rd_v[MAX_BITS-1:0] = rg_q.tx;
            A_RXD:    rd_v[MAX_BITS-1:0] = rg_q.rx;
            A_CAUSE:  rd_v[0]            = rg_q.cause;
            A_TIMING: rd_v[B_DELAY +: 2] = rg_q.dly;
            default:  rd_v = '0;
        endcase
    end

    always_comb begin
        rg_d = rg_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    rg_d.cs_en  = bus_wdata[B_SEL_EN];
                    rg_d.cs_idx = bus_wdata[B_SEL_IDX +: CS_IDX_W];
                end
                A_CFG: begin
                    rg_d.wide   = bus_wdata[B_WIDE];
                    rg_d.cpol   = bus_wdata[B_CPOL];
                    rg_d.cpha   = bus_wdata[B_CPHA];
                    rg_d.tx_lsb = bus_wdata[B_TX_LSB];
                    rg_d.rx_lsb = bus_wdata[B_RX_LSB];
                end
                A_TXD:    if (!eng_busy) rg_d.tx = bus_wdata[MAX_BITS-1:0];
                A_CAUSE:  if (!bus_wdata[0]) rg_d.cause = 1'b0;
                A_TIMING: rg_d.dly = bus_wdata[B_DELAY +: 2];
                default:  ;
            endcase
        end
        if (eng_done) begin
            rg_d.cause = 1'b1;
            rg_d.rx    = eng_rx;
        end
        if (bus_rd) rg_d.rdata = rd_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= '0;
            rg_q.dly <= 2'd1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign bus_rdata = rg_q.rdata;

    spi_half_tick #(.HALF(SCLK_HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_run),
        .tick_o (tick)
    );

    spi_shift_core #(.MAX_BITS(MAX_BITS)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .word_i      (bus_wdata[MAX_BITS-1:0]),
        .cfg_i       (eng_cfg),
        .idle_cpol_i (rg_q.cpol),
        .tick_i      (tick),
        .miso_i      (spi_miso),
        .run_o       (eng_run),
        .busy_o      (eng_busy),
        .done_o      (eng_done),
        .sclk_o      (spi_sclk),
        .mosi_o      (spi_mosi),
        .rx_o        (eng_rx)
    );

    spi_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
        .en_i   (rg_q.cs_en),
        .idx_i  (rg_q.cs_idx),
        .cs_n_o (spi_cs_n)
    );

    // R2: no chip select active while the enable bit is clear
    p_cs_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.cs_en |-> (&spi_cs_n))
        else $error("chip select low while disabled");

    // R2: at most one chip select low
    p_cs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1)
        else $error("several chip selects low");

    // R7: an idle transmit write starts the engine
    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !eng_busy) |=> eng_busy)
        else $error("transfer did not start");

    // R9: a transmit write during a transfer leaves the register alone
    p_tx_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && eng_busy) |=> $stable(rg_q.tx))
        else $error("transmit register changed while busy");

    // R8: completion raises the cause flag
    p_cause_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> rg_q.cause)
        else $error("cause flag not raised");
endmodule

// File: tb/spi_word_master_tb_top.sv
module spi_word_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [7:0]  cs_n;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_word_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    // slave model state
    logic        cpol_b = 0, cpha_b = 0, glitch_en = 0, slv_clr = 0;
    logic [15:0] slave_word = '0, mosi_bits = '0;
    logic        sclk_prev = 0, glitch_on = 0, glitch_arm = 0;
    int          lead_n = 0, trail_n = 0, samp_n = 0, glitch_cnt = 0, sidx = 0;
    logic        mon_on = 0, cs_bad = 0;
    logic [7:0]  cs_exp = 8'hFF;
    logic        lead;

    initial miso = 1'b0;

    always @(negedge clk) begin
        if (slv_clr) begin
            lead_n = 0; trail_n = 0; samp_n = 0; glitch_cnt = 0;
            glitch_on = 0; glitch_arm = 0; mosi_bits = '0; slv_clr = 0;
        end else if (sclk != sclk_prev) begin
            lead = (sclk != cpol_b);
            if (lead) lead_n++; else trail_n++;
            if (lead ^ cpha_b) begin
                if (samp_n < 16) mosi_bits[samp_n] = mosi;
                samp_n++; glitch_arm = 1; glitch_cnt = 0;
            end else begin
                glitch_arm = 0; glitch_on = 0;
            end
        end else if (glitch_arm) begin
            glitch_cnt++;
            if (glitch_cnt == 2) glitch_on = 1;
        end
        sclk_prev = sclk;
        sidx = cpha_b ? lead_n - 1 : trail_n;
        miso = (sidx >= 0 && sidx < 16) ? (slave_word[sidx] ^ (glitch_en & glitch_on)) : 1'b0;
        if (mon_on && cs_n !== cs_exp) cs_bad = 1;
    end

    function automatic logic [15:0] f_order(logic [15:0] w, int n, logic lsb);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < n; i++) r[i] = lsb ? w[i] : w[n-1-i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(posedge clk); @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic wait_cause(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            rd(4'd4, v);
            if (v != 0) begin ok = 1; break; end
        end
    endtask

    // configure, run one word, check everything observable
    task automatic xfer(input int idx, input logic wide, input logic cpol, input logic cpha,
                        input logic txl, input logic rxl, input logic [1:0] dly,
                        input logic [15:0] tx, input logic [15:0] sw, input logic gl,
                        input logic inv_exp);
        int n;
        bit ok;
        logic [31:0] v;
        logic [15:0] mask, exp_rx;
        n = wide ? 16 : 8;
        mask = wide ? 16'hFFFF : 16'h00FF;
        wr(4'd0, 32'(1 | (idx << 2)));
        wr(4'd1, 32'((wide << 5) | (cpol << 11) | (cpha << 12) | (txl << 13) | (rxl << 14)));
        wr(4'd6, 32'(dly) << 6);
        cpol_b = cpol; cpha_b = cpha; glitch_en = gl; slave_word = sw;
        cs_exp = ~(8'd1 << idx);
        slv_clr = 1;
        @(negedge clk); @(negedge clk);
        chk(sclk == cpol, "R3 idle sclk level", 32'(sclk), 32'(cpol));
        mon_on = 1;
        wr(4'd2, 32'(tx));
        wait_cause(ok);
        chk(ok, "R8 cause nonzero after word", 32'(ok), 1);
        chk(mosi_bits == f_order(tx & mask, n, txl), "R5 R3 MOSI bit sequence",
            32'(mosi_bits), 32'(f_order(tx & mask, n, txl)));
        chk(lead_n == n, "R4 SCLK pulse count", 32'(lead_n), 32'(n));
        exp_rx = f_order(sw & mask, n, rxl);
        if (inv_exp) exp_rx = ~exp_rx & mask;
        rd(4'd3, v);
        chk(v == 32'(exp_rx), "R11 R6 R10 received word", v, 32'(exp_rx));
        chk(!cs_bad, "R2 chip select held during word", 32'(cs_n), 32'(cs_exp));
        wr(4'd4, 32'd0);
        rd(4'd4, v);
        chk(v == 0, "R8 cause cleared by zero write", v, 0);
        mon_on = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        bit ok;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 8'hFF, "R1 chip selects high", 32'(cs_n), 32'hFF);
        chk(sclk == 0, "R1 sclk low", 32'(sclk), 0);
        rd(4'd0, v); chk(v == 0, "R1 control reset", v, 0);
        rd(4'd1, v); chk(v == 0, "R1 config reset", v, 0);
        rd(4'd2, v); chk(v == 0, "R1 transmit reset", v, 0);
        rd(4'd3, v); chk(v == 0, "R1 receive reset", v, 0);
        rd(4'd4, v); chk(v == 0, "R1 cause reset", v, 0);
        rd(4'd6, v); chk(v == 32'h40, "R1 timing reset", v, 32'h40);

        // R2 decode of every index
        for (int i = 0; i < 8; i++) begin
            wr(4'd0, 32'(1 | (i << 2)));
            @(negedge clk);
            chk(cs_n == ~(8'd1 << i), "R2 chip select decode", 32'(cs_n), 32'(~(8'd1 << i)));
            rd(4'd0, v);
            chk(v == 32'(1 | (i << 2)), "R2 control readback", v, 32'(1 | (i << 2)));
        end
        wr(4'd0, 32'(5 << 2));
        @(negedge clk);
        chk(cs_n == 8'hFF, "R2 enable clear releases all", 32'(cs_n), 32'hFF);

        // directed: all four modes, both sizes
        for (int m = 0; m < 8; m++)
            xfer(m, m[2], m[0], m[1], 0, 0, 2'd1, 16'hA5C3, 16'h3C96, 0, 0);

        // random mix
        for (int k = 0; k < 24; k++) begin
            logic [31:0] r;
            r = $urandom;
            xfer(int'(r[2:0]), r[3], r[4], r[5], r[6], r[7], r[9:8],
                 16'($urandom), 16'($urandom), 0, 0);
        end

        // R10 late MISO change separates delay 1 from delay 2
        xfer(3, 1, 0, 0, 0, 0, 2'd1, 16'h1234, 16'hB1E7, 1, 0);
        xfer(3, 1, 0, 0, 0, 0, 2'd2, 16'h1234, 16'hB1E7, 1, 1);
        xfer(6, 0, 1, 1, 1, 1, 2'd2, 16'h0081, 16'h005A, 1, 1);
        glitch_en = 0;

        // R9 write during a transfer, R7 busy flag
        wr(4'd0, 32'(1 | (2 << 2)));
        wr(4'd1, 32'd0);
        wr(4'd6, 32'h40);
        cpol_b = 0; cpha_b = 0; slave_word = 16'h00F0; cs_exp = ~8'h04;
        slv_clr = 1;
        @(negedge clk); @(negedge clk);
        wr(4'd2, 32'h0000_00C5);
        rd(4'd0, v);
        chk(v[1] == 1'b1, "R7 busy while shifting", v, 32'h0B);
        wr(4'd2, 32'h0000_003A);
        wait_cause(ok);
        chk(mosi_bits == f_order(16'h00C5, 8, 0), "R9 word unchanged by busy write",
            32'(mosi_bits), 32'(f_order(16'h00C5, 8, 0)));
        rd(4'd2, v);
        chk(v == 32'hC5, "R9 transmit readback unchanged", v, 32'hC5);
        rd(4'd0, v);
        chk(v[1] == 1'b0, "R7 busy clear after word", v, 32'h09);
        wr(4'd4, 32'd0);

        // R2 two-word frame with chip select held throughout
        cs_bad = 0;
        xfer(5, 0, 0, 1, 0, 1, 2'd1, 16'h0011, 16'h0022, 0, 0);
        mon_on = 1;
        xfer(5, 0, 0, 1, 0, 1, 2'd1, 16'h0033, 16'h0044, 0, 0);
        chk(!cs_bad && cs_n == 8'hDF, "R2 chip select held across frame", 32'(cs_n), 32'hDF);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule